// File: doc/BRIEF.md
# Sensor Telemetry Frame Generator

This block turns a set of parallel sensor readings into a fixed-length byte stream for a serial transmitter. One pulse on a sample strobe latches six 10-bit channel samples and four push-button levels together. The block then sends a 17-byte frame, one byte per handshake, over a ready/valid byte port. Because all inputs are latched in one cycle, a frame never holds a mix of old and new data, even if the inputs change while it is being sent.

Each frame starts with a two-byte sync pattern. Next come a constant version byte and an 8-bit frame number that wraps. The twelve channel bytes follow, and the frame closes with a packed button byte. At 256 frames per second and a UART clearing a byte every few microseconds, each frame finishes long before the next strobe. A strobe that does arrive while a frame is still in flight is reported on a one-cycle overrun pulse and then discarded.

Top module: `sensor_frame_gen`

## Requirements
- R1: After reset, `tx_valid` and `overrun` are 0, and the first frame sent carries frame number 0.
- R2: A strobe taken while `tx_valid` is low raises `tx_valid` on the next cycle. Exactly 17 bytes are then accepted. `tx_valid` is low in the cycle after the 17th handshake.
- R3: Byte positions 0 and 1 of every frame are 0xA5 and 0x5A.
- R4: Position 2 is the `VERSION` parameter (default 0x01). Position 3 is the current frame number.
- R5: Positions 4 to 15 carry channels 0 to 5 in rising order. Channel c is taken from `ch_samples[c*10 +: 10]`. For each channel the low byte (sample bits 7:0) comes first, then the high byte, which holds sample bits 9:8 in bits 1:0 with bits 7:2 zero.
- R6: Position 16 holds `buttons[3:0]` in bits 3:0, with button 0 in bit 0 and bits 7:4 zero.
- R7: Channel and button values are those present in the strobe cycle. Changes to them during a frame do not alter that frame.
- R8: The frame number rises by one after each completed frame and wraps from 255 to 0.
- R9: A strobe while `tx_valid` is high gives a one-cycle `overrun` pulse on the next cycle. It neither restarts nor extends the frame in flight.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` keeps its value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | Latches all inputs and starts a frame when idle |
| ch_samples | input | 60 | Six 10-bit samples, channel c at bits c*10+9:c*10 |
| buttons | input | 4 | Button levels, button 0 in bit 0 |
| tx_data | output | 8 | Current frame byte |
| tx_valid | output | 1 | `tx_data` holds a byte to send |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |
| overrun | output | 1 | One-cycle pulse for a dropped strobe |

## Verification
A wrong byte index or a wrong latch enable shows up in `tx_data` on the very handshake where the index goes astray. The bench model compares every byte as it is accepted, so such a fault is caught within one cycle. A frame counter that steps wrongly appears only at position 3 of the following frame. Counter wrap is therefore covered by running more than 256 frames. A handshake fault, such as advancing while ready is low, breaks the hold check in the stalled cycle itself. Randomised ready patterns exercise this repeatedly.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t SYNC_HI = 8'hA5;
  localparam byte_t SYNC_LO = 8'h5A;
  localparam int    HDR_BYTES = 4;
  localparam int    TRL_BYTES = 1;
endpackage

// File: rtl/sfg_capture.sv
module sfg_capture #(
  parameter int NUM_CH   = 6,
  parameter int SAMPLE_W = 10,
  parameter int NUM_BTN  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples_in,
  input  logic [NUM_BTN-1:0]         btn_in,
  output logic [NUM_CH*SAMPLE_W-1:0] samples_q,
  output logic [NUM_BTN-1:0]         btn_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      samples_q <= '0;
      btn_q     <= '0;
    end else if (load) begin
      samples_q <= samples_in;
      btn_q     <= btn_in;
    end
  end
endmodule

// File: rtl/sfg_byte_sel.sv
module sfg_byte_sel
  import sfg_pkg::*;
#(
  parameter int    NUM_CH   = 6,
  parameter int    SAMPLE_W = 10,
  parameter int    NUM_BTN  = 4,
  parameter byte_t VERSION  = 8'h01,
  localparam int   FRAME_LEN = HDR_BYTES + 2*NUM_CH + TRL_BYTES,
  localparam int   IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic [IDX_W-1:0]           idx,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples_q,
  input  logic [NUM_BTN-1:0]         btn_q,
  input  byte_t                      frame_no,
  output byte_t                      sel_byte
);
  logic [15:0] word;
  byte_t       btn_byte;

  always_comb begin
    btn_byte = '0;
    btn_byte[NUM_BTN-1:0] = btn_q;
    word = '0;
    sel_byte = '0;
    if (idx == IDX_W'(0))                sel_byte = SYNC_HI;
    else if (idx == IDX_W'(1))           sel_byte = SYNC_LO;
    else if (idx == IDX_W'(2))           sel_byte = VERSION;
    else if (idx == IDX_W'(3))           sel_byte = frame_no;
    else if (idx == IDX_W'(FRAME_LEN-1)) sel_byte = btn_byte;
    else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (idx == IDX_W'(HDR_BYTES + 2*c) || idx == IDX_W'(HDR_BYTES + 2*c + 1)) begin
          word = '0;
          word[SAMPLE_W-1:0] = samples_q[c*SAMPLE_W +: SAMPLE_W];
          sel_byte = idx[0] ? word[15:8] : word[7:0];
        end
      end
    end
  end
endmodule

// File: rtl/sfg_sequencer.sv
module sfg_sequencer
  import sfg_pkg::*;
#(
  parameter int   NUM_CH    = 6,
  localparam int  FRAME_LEN = HDR_BYTES + 2*NUM_CH + TRL_BYTES,
  localparam int  IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_stb,
  input  logic             tx_ready,
  input  byte_t            sel_byte,
  output logic [IDX_W-1:0] sel_idx,
  output logic             start,
  output byte_t            frame_no,
  output byte_t            tx_data,
  output logic             tx_valid,
  output logic             overrun
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN-1);

  logic [IDX_W-1:0] cur_idx;
  logic accept, last;

  assign start   = sample_stb && !tx_valid;
  assign accept  = tx_valid && tx_ready;
  assign last    = (cur_idx == LAST);
  assign sel_idx = start ? '0 : cur_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      cur_idx  <= '0;
      frame_no <= '0;
      overrun  <= 1'b0;
    end else begin
      overrun <= sample_stb && tx_valid;
      if (start) begin
        tx_valid <= 1'b1;
        cur_idx  <= '0;
        tx_data  <= sel_byte;
      end else if (accept) begin
        if (last) begin
          tx_valid <= 1'b0;
          frame_no <= frame_no + 8'd1;
        end else begin
          cur_idx <= sel_idx;
          tx_data <= sel_byte;
        end
      end
    end
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R10
  AST_FIRST_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> tx_data == SYNC_HI); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    sample_stb && tx_valid && !tx_ready |=> tx_valid && $stable(cur_idx)); // R9
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
    accept && last |=> !tx_valid && frame_no == 8'($past(frame_no) + 8'd1)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    cur_idx <= LAST); // R2
endmodule

// File: rtl/sensor_frame_gen.sv
module sensor_frame_gen
  import sfg_pkg::*;
#(
  parameter int    NUM_CH   = 6,
  parameter int    SAMPLE_W = 10,
  parameter int    NUM_BTN  = 4,
  parameter byte_t VERSION  = 8'h01,
  localparam int   FRAME_LEN = HDR_BYTES + 2*NUM_CH + TRL_BYTES,
  localparam int   IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sample_stb,
  input  logic [NUM_CH*SAMPLE_W-1:0] ch_samples,
  input  logic [NUM_BTN-1:0]         buttons,
  output logic [7:0]                 tx_data,
  output logic                       tx_valid,
  input  logic                       tx_ready,
  output logic                       overrun
);
  logic [NUM_CH*SAMPLE_W-1:0] samples_q;
  logic [NUM_BTN-1:0]         btn_q;
  logic [IDX_W-1:0]           sel_idx;
  logic                       start;
  byte_t                      frame_no, sel_byte;

  sfg_capture #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .NUM_BTN(NUM_BTN)) u_cap (
    .clk(clk), .rst(rst), .load(start), .samples_in(ch_samples), .btn_in(buttons),
    .samples_q(samples_q), .btn_q(btn_q));

  sfg_byte_sel #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .NUM_BTN(NUM_BTN),
                 .VERSION(VERSION)) u_sel (
    .idx(sel_idx), .samples_q(samples_q), .btn_q(btn_q), .frame_no(frame_no),
    .sel_byte(sel_byte));

  sfg_sequencer #(.NUM_CH(NUM_CH)) u_seq (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .tx_ready(tx_ready),
    .sel_byte(sel_byte), .sel_idx(sel_idx), .start(start), .frame_no(frame_no),
    .tx_data(tx_data), .tx_valid(tx_valid), .overrun(overrun));
endmodule

// File: tb/sensor_frame_gen_tb.sv
module sensor_frame_gen_tb;
  localparam int NCH = 6;
  localparam logic [7:0] VER = 8'h01;

  logic clk = 1'b0, rst = 1'b1, sample_stb = 1'b0, tx_ready, overrun, tx_valid;
  logic [NCH*10-1:0] ch_samples = '0;
  logic [3:0] buttons = '0;
  logic [7:0] tx_data;
  bit rand_ready = 1'b0, done_flag = 1'b0;
  int n_chk = 0, n_fail = 0, ovr_seen = 0;
  byte unsigned got[$];

  always #5 clk = ~clk;

  sensor_frame_gen u_dut (.clk(clk), .rst(rst), .sample_stb(sample_stb),
    .ch_samples(ch_samples), .buttons(buttons), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .overrun(overrun));

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(int p);
    if (p < 2) return "R3 sync";
    if (p < 4) return "R4 header";
    if (p < 16) return "R5 channel";
    return "R6 buttons";
  endfunction

  initial tx_ready = 1'b1;
  always @(posedge clk) begin
    #2;
    tx_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // behavioural reference model
  bit m_valid = 0, m_ovr = 0;
  int m_data = 0, m_pos = 0, m_frame = 0;
  int q[$];
  always @(posedge clk) begin
    if (rst) begin
      m_valid = 0; m_ovr = 0; m_frame = 0; q.delete();
    end else begin
      m_ovr = sample_stb && m_valid;
      if (m_valid && tx_ready) begin
        if (q.size() == 0) begin
          m_valid = 0;
          m_frame = (m_frame + 1) % 256;
        end else begin
          m_data = q.pop_front();
          m_pos++;
        end
      end else if (!m_valid && sample_stb) begin
        q.delete();
        q.push_back(8'hA5); q.push_back(8'h5A); q.push_back(VER); q.push_back(m_frame);
        for (int c = 0; c < NCH; c++) begin
          q.push_back(ch_samples[c*10 +: 8]);
          q.push_back({6'b0, ch_samples[c*10+8 +: 2]});
        end
        q.push_back({4'b0, buttons});
        m_data = q.pop_front();
        m_pos = 0;
        m_valid = 1;
      end
    end
  end

  bit hold_flag = 0;
  int hold_d = 0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(tx_valid === m_valid, "R2 valid", tx_valid, m_valid);
      if (m_valid) chk(tx_data === m_data[7:0], tag_of(m_pos), tx_data, m_data);
      chk(overrun === m_ovr, "R9 overrun", overrun, m_ovr);
      if (overrun) ovr_seen++;
      if (hold_flag) chk(tx_valid && tx_data == hold_d, "R10 hold", tx_data, hold_d);
      hold_flag = tx_valid && !tx_ready;
      hold_d = tx_data;
      if (tx_valid && tx_ready) got.push_back(tx_data);
    end
  end

  task automatic pulse();
    @(posedge clk); #2 sample_stb = 1'b1;
    @(posedge clk); #2 sample_stb = 1'b0;
  endtask

  task automatic wait_done();
    while (!tx_valid) @(negedge clk);
    while (tx_valid) @(negedge clk);
  endtask

  task automatic set_pattern(int seed);
    for (int c = 0; c < NCH; c++) ch_samples[c*10 +: 10] = 10'((seed * 97 + c * 181) ^ 10'h2A5);
    buttons = 4'(seed * 5 + 9);
  endtask

  task automatic check_frame(logic [NCH*10-1:0] s, logic [3:0] b, int fr, string t);
    chk(got.size() == 17, {t, " R2 length"}, got.size(), 17);
    if (got.size() == 17) begin
      chk(got[0] == 8'hA5 && got[1] == 8'h5A, {t, " R3"}, {got[0], got[1]}, 16'hA55A);
      chk(got[2] == VER, {t, " R4 version"}, got[2], VER);
      chk(got[3] == fr, {t, " R4 frame"}, got[3], fr);
      for (int c = 0; c < NCH; c++) begin
        chk(got[4+2*c] == s[c*10 +: 8], {t, " R5 low"}, got[4+2*c], s[c*10 +: 8]);
        chk(got[5+2*c] == {6'b0, s[c*10+8 +: 2]}, {t, " R5 high"}, got[5+2*c], s[c*10+8 +: 2]);
      end
      chk(got[16] == {4'b0, b}, {t, " R6"}, got[16], b);
    end
  endtask

  initial begin
    logic [NCH*10-1:0] s_keep;
    logic [3:0] b_keep;
    int fr;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(tx_valid == 0, "R1 valid", tx_valid, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);

    set_pattern(1); got.delete(); pulse(); wait_done();
    check_frame(ch_samples, buttons, 0, "R1 first");

    set_pattern(2); s_keep = ch_samples; b_keep = buttons; got.delete(); pulse();
    repeat (3) @(posedge clk);
    #2 set_pattern(3);
    wait_done();
    check_frame(s_keep, b_keep, 1, "R7 latch");

    set_pattern(4); s_keep = ch_samples; b_keep = buttons; got.delete(); ovr_seen = 0; pulse();
    repeat (3) @(posedge clk);
    pulse();
    wait_done();
    check_frame(s_keep, b_keep, 2, "R9 drop");
    chk(ovr_seen == 1, "R9 pulse count", ovr_seen, 1);
    repeat (5) @(negedge clk);
    chk(tx_valid == 0, "R9 no restart", tx_valid, 0);

    rand_ready = 1'b1;
    fr = 3;
    while (fr < 256) begin
      set_pattern(fr); s_keep = ch_samples; b_keep = buttons; got.delete(); pulse(); wait_done();
      if (fr == 3 || fr == 255) check_frame(s_keep, b_keep, fr, "R10 stalls");
      fr++;
    end
    set_pattern(7); s_keep = ch_samples; b_keep = buttons; got.delete(); pulse(); wait_done();
    check_frame(s_keep, b_keep, 0, "R8 wrap");

    done_flag = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule